// File: doc/BRIEF.md
# Frame-Synced Serial Word Transmitter

This block is a host-side serial master that delivers 16-bit command and data words to a frequency synthesizer over three wires: a serial clock, a serial data line and an active-low frame sync. Software places a word on the parallel input and pulses a write strobe while the transmit-ready flag is high. The block then pulls frame sync low and waits one bit period with the clock held high. After that it shifts the word out most significant bit first, with each bit stable across the falling clock edge on which the receiver samples it. At the end of the sixteenth bit period it releases frame sync and parks the clock high until the next word.

The bit rate comes from a programmable divide value. One bit period lasts (divide value + 1) system clocks, so a divide value of 49 on a 100 MHz system clock gives a 2 MHz serial clock. The divide value is captured together with the word. The serial clock toggles only while a word is in flight. A write made while the ready flag is low is dropped and sets a sticky overrun flag, so firmware that polls the ready flag never loses a word, even at full speed.

The control is a three-state machine. The states are `ST_IDLE` (ready, frame sync high, clock high), `ST_LEAD` (frame sync low, clock held high for one bit period) and `ST_SHIFT` (sixteen clocked bit periods). It has four transitions. IDLE→LEAD happens on an accepted write. LEAD→SHIFT happens at the end of the lead period. SHIFT→SHIFT happens at the end of each bit period while bits remain. SHIFT→IDLE happens at the end of the last bit period.

Top module: `sxt_tx`

## Requirements
- R1: After reset, ready_o=1, fsync_n_o=1, sclk_o=1, sdata_o=0 and overrun_o=0.
- R2: A write (wr_i=1 while ready_o=1) is accepted on that clock edge. From the next cycle, ready_o=0 and fsync_n_o=0, and both stay so for exactly 17·P cycles, where P is the bit period in system clocks.
- R3: P = div_i+1 with div_i captured at acceptance, except that div_i=0 is treated as 1 (P=2). In each bit period the serial clock is high for P−⌊P/2⌋ cycles and then low for ⌊P/2⌋ cycles.
- R4: During the first bit period after fsync_n_o falls, sclk_o stays high and no falling clock edge occurs (one-bit data delay). The first falling edge comes P+(P−⌊P/2⌋) cycles after frame sync falls.
- R5: Each frame carries exactly 16 falling edges of sclk_o. The sdata_o values sampled on them, in order, are wdata_i bits 15 down to 0. sdata_o does not change while sclk_o is low.
- R6: fsync_n_o returns high at the end of the sixteenth bit period. Whenever fsync_n_o is high, sclk_o=1 and sdata_o=0.
- R7: A write while ready_o=0 is ignored: the frame in flight keeps its word and timing, and no extra frame is sent. The write sets overrun_o=1 from the next cycle.
- R8: overrun_o, once set, stays 1 until reset. Reset clears it, and writes after that work normally.
- R9: A write in the first cycle that ready_o is back at 1 is accepted, so words can go out back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W (8) | Divide value; bit period is div_i+1 clocks |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | WORD_W (16) | Word to transmit |
| ready_o | output | 1 | 1 when a new word may be written |
| overrun_o | output | 1 | Sticky flag: a write arrived while busy |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, MSB first |
| fsync_n_o | output | 1 | Active-low frame sync |

## Verification
All outputs are decoded from registers, so a write accepted at one edge shows as ready_o=0 and fsync_n_o=0 in the very next cycle. Ready returns exactly 17·P cycles later. The bench counts cycles from the first low frame-sync sample. It expects bit i's falling clock edge at cycle P·(i+1)+P−⌊P/2⌋ and frame sync's last low sample at cycle 17·P−1. A rejected write shows in overrun_o one cycle later. All outputs are sampled on the falling system-clock edge, midway between the register updates, so each result is read in the cycle the count above predicts.

// File: rtl/sxt_pkg.sv
package sxt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } sxt_state_e;
endpackage

// File: rtl/sxt_div.sv
// Bit-period counter: counts 0..div while run is high, flags the low phase
// and the last cycle of each bit period.
module sxt_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             last,
    output logic             low_phase
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [CW-1:0]    period;
    logic [CW-1:0]    high_len;

    assign period    = {1'b0, div} + CW'(1);
    assign high_len  = period - (period >> 1);
    assign last      = run && (cnt_q == div);
    assign low_phase = run && ({1'b0, cnt_q} >= high_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sxt_shreg.sv
// Parallel-load shift register, MSB presented first.
module sxt_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] q;

    assign msb = q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sxt_tx.sv
module sxt_tx
    import sxt_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              overrun_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              fsync_n_o
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    sxt_state_e       state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic [DIV_W-1:0] div_q;
    logic             overrun_q;
    logic             accept, reject;
    logic             run, per_last, low_phase, msb;

    assign accept = wr_i && (state_q == ST_IDLE);
    assign reject = wr_i && (state_q != ST_IDLE);
    assign run    = (state_q != ST_IDLE);

    sxt_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (div_q),
        .last      (per_last),
        .low_phase (low_phase)
    );

    sxt_shreg #(.W(WORD_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (state_q == ST_SHIFT && per_last),
        .din   (wdata_i),
        .msb   (msb)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_d = ST_LEAD;
            ST_LEAD:  if (per_last) state_d = ST_SHIFT;
            ST_SHIFT: if (per_last && bit_q == LAST_BIT) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers: bit index, captured divider, sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            div_q     <= DIV_W'(1);
            overrun_q <= 1'b0;
        end else begin
            if (accept) begin
                bit_q <= '0;
                div_q <= (div_i == '0) ? DIV_W'(1) : div_i;
            end else if (state_q == ST_SHIFT && per_last) begin
                bit_q <= bit_q + BIT_W'(1);
            end
            if (reject) begin
                overrun_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready_o   = 1'b0;
        fsync_n_o = 1'b0;
        sclk_o    = 1'b1;
        sdata_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o   = 1'b1;
                fsync_n_o = 1'b1;
            end
            ST_LEAD: begin
                sclk_o = 1'b1;
            end
            ST_SHIFT: begin
                sclk_o  = ~low_phase;
                sdata_o = msb;
            end
            default: begin
                fsync_n_o = 1'b1;
            end
        endcase
        overrun_o = overrun_q;
    end
endmodule

// File: rtl/sxt_chk.sv
module sxt_chk #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic wr_i,
    input logic ready_o,
    input logic overrun_o,
    input logic sclk_o,
    input logic sdata_o,
    input logic fsync_n_o
);
    logic       prev_fs, prev_sclk;
    logic [7:0] nfall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_fs   <= 1'b1;
            prev_sclk <= 1'b1;
            nfall     <= '0;
        end else begin
            prev_fs   <= fsync_n_o;
            prev_sclk <= sclk_o;
            if (fsync_n_o) begin
                nfall <= '0;
            end else if (prev_sclk && !sclk_o) begin
                nfall <= nfall + 8'd1;
            end
        end
    end

    p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_n_o |-> (sclk_o && !sdata_o));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && !$past(sclk_o)) |-> $stable(sdata_o));

    p_frame_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_n_o && !prev_fs) |-> (nfall == 8'(WORD_W)));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ready_o) |=> (!ready_o && !fsync_n_o));

    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ready_o) |=> overrun_o);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_n_o && prev_fs) |-> sclk_o);
endmodule

bind sxt_tx sxt_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_i),
    .ready_o   (ready_o),
    .overrun_o (overrun_o),
    .sclk_o    (sclk_o),
    .sdata_o   (sdata_o),
    .fsync_n_o (fsync_n_o)
);

// File: tb/sxt_tx_tb.sv
`timescale 1ns/1ps
module sxt_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_i = 8'd1;
    logic        wr_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic        ready_o, overrun_o, sclk_o, sdata_o, fsync_n_o;

    int total = 0;
    int bad = 0;
    int wd = 0;

    always #4 clk = ~clk;

    sxt_tx u_dut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .ready_o(ready_o), .overrun_o(overrun_o), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .fsync_n_o(fsync_n_o)
    );

    function automatic int f_per(int d);
        return (d == 0) ? 2 : d + 1;
    endfunction

    function automatic int f_high(int p);
        return p - p / 2;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
            report();
        end
    end

    // expected frames
    int exp_w[$];
    int exp_p[$];

    // line monitor, sampled on the falling system-clock edge
    logic        prev_fs = 1'b1, prev_sclk = 1'b1, prev_sd = 1'b0;
    int          cyc = 0, nf = 0, cur_w = 0, cur_p = 2;
    logic [15:0] got = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fsync_n_o && prev_fs) begin
                chk(exp_w.size() > 0, "R7 unexpected frame", 0, 1);
                if (exp_w.size() > 0) begin
                    cur_w = exp_w.pop_front();
                    cur_p = exp_p.pop_front();
                end
                cyc = 0; nf = 0; got = '0;
            end else if (!fsync_n_o) begin
                cyc++;
            end
            if (!fsync_n_o && prev_sclk && !sclk_o) begin
                chk(cyc == cur_p * (nf + 1) + f_high(cur_p),
                    (nf == 0) ? "R4 first fall" : "R3 fall time",
                    cyc, cur_p * (nf + 1) + f_high(cur_p));
                got = {got[14:0], sdata_o};
                nf++;
            end
            if (fsync_n_o && !prev_fs) begin
                chk(nf == 16, "R5 fall count", nf, 16);
                chk(got == cur_w[15:0], "R5 word", int'(got), cur_w);
                chk(cyc == 17 * cur_p - 1, "R6 frame end", cyc, 17 * cur_p - 1);
            end
            if (fsync_n_o) begin
                chk(sclk_o && !sdata_o, "R6 idle lines", {sclk_o, sdata_o}, 2);
            end
            if (!sclk_o && !prev_sclk) begin
                chk(sdata_o == prev_sd, "R5 data hold", sdata_o, prev_sd);
            end
        end
        prev_fs   = fsync_n_o;
        prev_sclk = sclk_o;
        prev_sd   = sdata_o;
    end

    // write a word, optionally inject a busy write, wait for completion
    task automatic send(logic [15:0] w, int d, bit inject, bit b2b);
        int busy;
        int p;
        p = f_per(d);
        if (b2b) chk(ready_o == 1'b1, "R9 ready at return", ready_o, 1);
        while (!ready_o) @(negedge clk);
        exp_w.push_back(int'(w));
        exp_p.push_back(p);
        wr_i = 1'b1; wdata_i = w; div_i = 8'(d);
        @(negedge clk);
        wr_i = 1'b0;
        chk(!ready_o && !fsync_n_o, b2b ? "R9 accept" : "R2 accept",
            {ready_o, fsync_n_o}, 0);
        busy = 0;
        while (!ready_o) begin
            busy++;
            if (inject && busy == 4) begin
                wr_i = 1'b1; wdata_i = ~w; div_i = 8'(d + 2);
            end
            @(negedge clk);
            wr_i = 1'b0;
            if (inject && busy == 4) chk(overrun_o == 1'b1, "R7 overrun set", overrun_o, 1);
        end
        chk(busy == 17 * p, "R2 busy length", busy, 17 * p);
    endtask

    task automatic chk_reset_state(string tag);
        chk(ready_o && fsync_n_o && sclk_o && !sdata_o && !overrun_o, tag,
            {ready_o, fsync_n_o, sclk_o, sdata_o, overrun_o}, 5'b11100);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_reset_state("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("R1 after release");

        // directed corners
        send(16'hA5C3, 1, 0, 0);
        send(16'hFFFF, 0, 0, 1);   // R9 back to back, R3 zero clamp
        send(16'h0000, 2, 0, 1);   // odd period
        send(16'h8001, 49, 0, 0);
        send(16'h1234, 3, 0, 0);
        chk(overrun_o == 1'b0, "R7 no false overrun", overrun_o, 0);

        // random words and dividers
        for (int i = 0; i < 40; i++) begin
            send(16'($urandom), int'($urandom_range(7, 0)), 0, (i % 3) == 0);
        end
        chk(overrun_o == 1'b0, "R7 clean after random", overrun_o, 0);

        // ignored write during a frame
        send(16'h5A0F, 4, 1, 0);
        send(16'hC001, 2, 0, 1);
        chk(overrun_o == 1'b1, "R8 sticky", overrun_o, 1);
        repeat (5) @(negedge clk);
        chk(exp_w.size() == 0, "R7 no extra frame", exp_w.size(), 0);
        chk(overrun_o == 1'b1, "R8 sticky idle", overrun_o, 1);

        // reset clears overrun
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("R8 reset clears");
        rst_n = 1'b1;
        @(negedge clk);
        send(16'h7E81, 5, 0, 0);
        chk(overrun_o == 1'b0, "R8 normal after reset", overrun_o, 0);
        repeat (4) @(negedge clk);
        report();
    end
endmodule